// File: doc/BRIEF.md
# Color Channel Multiplex Sequencer

This block produces the channel-select pattern for a digitizer front end that takes three color inputs (red, green, blue) into one converter. In cycling mode it steps through the three channels, one per pixel-phase strobe, in either forward (red, green, blue) or reverse (blue, green, red) order. In single mode it stays on one channel, picked by a 2-bit field.

A line-start pulse loads the configuration inputs into an active copy and restarts the cycle at the first channel of the chosen order. Between line starts, changes on the configuration inputs have no effect, so the order never changes partway through a line. Each accepted pixel-phase strobe gives a sample pulse one cycle later. The pulse carries a channel tag for the channel that was selected when the strobe arrived.

Top module: `color_mux_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release, `sel_o` is 3'b001 (red), `sample_o` is 0, `tag_o` is 0 and `err_o` is 0. The active configuration is cycling mode, forward order, until the first line start.
- R2: In cycling mode with forward order, each accepted strobe moves `sel_o` from red (bit 0) to green (bit 1), from green to blue (bit 2), and from blue back to red.
- R3: In cycling mode with reverse order (`cfg_reverse_i`=1), each accepted strobe moves `sel_o` from blue to green, from green to red, and from red back to blue.
- R4: A line start moves `sel_o` to the first channel of the newly loaded order: red for forward, blue for reverse. A strobe in the same cycle as a line start is dropped and produces no sample.
- R5: `cfg_single_i`, `cfg_reverse_i` and `cfg_chan_i` are captured only in a cycle with `line_start_i` high. Changes at any other time do not alter `sel_o`.
- R6: In single mode (`cfg_single_i`=1), `sel_o` holds the channel coded by `cfg_chan_i` (00 red, 01 green, 10 blue), whatever strobes arrive. In cycling mode the field is ignored.
- R7: A line start that loads single mode with channel code 11 selects red and sets `err_o`. `err_o` stays set until reset. Code 11 in cycling mode does not set it.
- R8: One cycle after an accepted strobe, `sample_o` is high for one cycle. `tag_o` then gives the channel that was selected in the strobe cycle (0 red, 1 green, 2 blue). `tag_o` keeps its value between samples.
- R9: `sel_o` has exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Line/frame start pulse: loads the configuration and restarts the cycle |
| phase_i | input | 1 | Pixel-phase strobe |
| cfg_single_i | input | 1 | 1: single-channel mode, 0: cycling mode |
| cfg_reverse_i | input | 1 | 0: forward order, 1: reverse order |
| cfg_chan_i | input | 2 | Fixed channel code for single mode |
| sel_o | output | 3 | One-hot channel select (bit 0 red, bit 1 green, bit 2 blue) |
| sample_o | output | 1 | Sample strobe, one cycle after an accepted phase |
| tag_o | output | 2 | Channel code that goes with the sample |
| err_o | output | 1 | Sticky flag for the reserved channel code |

## Verification
The bench builds the block with the package defaults: three channels and a 2-bit code. With these values the reserved code 11 can actually be driven, and both wrap points (blue to red forward, red to blue reverse) come up within a few strobes. Line starts are placed to coincide with strobes and with configuration changes, so that priority and the capture-only-at-line-start rule are each exercised.

// File: rtl/color_seq_pkg.sv
package color_seq_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CODE_W = $clog2(NUM_CH + 1);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [NUM_CH-1:0] sel_t;

  typedef struct packed {
    logic  single;
    logic  reverse;
    code_t chan;
  } cfg_t;

  localparam code_t CODE_FIRST = code_t'(0);
  localparam code_t CODE_LAST  = code_t'(NUM_CH - 1);
endpackage

// File: rtl/color_cfg_shadow.sv
module color_cfg_shadow
  import color_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o,
  output logic err_o
);
  cfg_t cfg_q;
  logic err_q;
  logic bad_code;

  assign bad_code = cfg_i.single && (cfg_i.chan > CODE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (load_i) begin
      cfg_q <= cfg_i;
      err_q <= err_q | bad_code;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;
endmodule

// File: rtl/color_phase_ctr.sv
module color_phase_ctr
  import color_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  restart_i,
  input  logic  step_i,
  output code_t pos_o
);
  code_t pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= CODE_FIRST;
    end else if (restart_i) begin
      pos_q <= CODE_FIRST;
    end else if (step_i) begin
      pos_q <= (pos_q == CODE_LAST) ? CODE_FIRST : pos_q + code_t'(1);
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/color_chan_map.sv
module color_chan_map
  import color_seq_pkg::*;
(
  input  cfg_t  cfg_i,
  input  code_t pos_i,
  output code_t code_o,
  output sel_t  sel_o
);
  code_t cyc_code;
  code_t fix_code;

  always_comb begin
    cyc_code = cfg_i.reverse ? (CODE_LAST - pos_i) : pos_i;
    // reserved codes fall back to red
    fix_code = (cfg_i.chan > CODE_LAST) ? CODE_FIRST : cfg_i.chan;
    code_o   = cfg_i.single ? fix_code : cyc_code;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel_o[i] = (code_o == code_t'(i));
  end
endmodule

// File: rtl/color_mux_seq.sv
module color_mux_seq
  import color_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              phase_i,
  input  logic              cfg_single_i,
  input  logic              cfg_reverse_i,
  input  logic [CODE_W-1:0] cfg_chan_i,
  output logic [NUM_CH-1:0] sel_o,
  output logic              sample_o,
  output logic [CODE_W-1:0] tag_o,
  output logic              err_o
);
  cfg_t  cfg_in;
  cfg_t  cfg_act;
  code_t pos;
  code_t code;
  logic  take;
  logic  sample_q;
  code_t tag_q;
  logic  single_act;
  logic  reverse_act;

  assign cfg_in = '{single: cfg_single_i, reverse: cfg_reverse_i, chan: cfg_chan_i};
  // line start has priority over a coincident strobe
  assign take   = phase_i && !line_start_i;

  color_cfg_shadow u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (line_start_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_act),
    .err_o  (err_o)
  );

  color_phase_ctr u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (line_start_i),
    .step_i    (take && !cfg_act.single),
    .pos_o     (pos)
  );

  color_chan_map u_map (
    .cfg_i  (cfg_act),
    .pos_i  (pos),
    .code_o (code),
    .sel_o  (sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      tag_q    <= CODE_FIRST;
    end else begin
      sample_q <= take;
      if (take) tag_q <= code;
    end
  end

  assign sample_o    = sample_q;
  assign tag_o       = tag_q;
  assign single_act  = cfg_act.single;
  assign reverse_act = cfg_act.reverse;
endmodule

// File: rtl/color_mux_seq_chk.sv
module color_mux_seq_chk
  import color_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_start_i,
  input logic              phase_i,
  input logic [NUM_CH-1:0] sel_o,
  input logic              sample_o,
  input logic [CODE_W-1:0] tag_o,
  input logic              err_o,
  input logic              single_act,
  input logic              reverse_act
);
  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_tag_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && !line_start_i) |=>
      (sample_o && ($past(sel_o) == (sel_t'(1) << tag_o))));

  assert_ls_drops_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> !sample_o);

  assert_fwd_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && !line_start_i && !single_act && !reverse_act) |=>
      (sel_o == {$past(sel_o[NUM_CH-2:0]), $past(sel_o[NUM_CH-1])}));

  assert_rev_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && !line_start_i && !single_act && reverse_act) |=>
      (sel_o == {$past(sel_o[0]), $past(sel_o[NUM_CH-1:1])}));

  assert_single_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start_i && single_act) |=> $stable(sel_o));

  assert_cfg_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> ($stable(single_act) && $stable(reverse_act)));
endmodule

bind color_mux_seq color_mux_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_start_i (line_start_i),
  .phase_i      (phase_i),
  .sel_o        (sel_o),
  .sample_o     (sample_o),
  .tag_o        (tag_o),
  .err_o        (err_o),
  .single_act   (single_act),
  .reverse_act  (reverse_act)
);

// File: tb/color_mux_seq_test.sv
module color_mux_seq_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_start_i = 1'b0;
  logic       phase_i = 1'b0;
  logic       cfg_single_i = 1'b0;
  logic       cfg_reverse_i = 1'b0;
  logic [1:0] cfg_chan_i = 2'b00;
  logic [2:0] sel_o;
  logic       sample_o;
  logic [1:0] tag_o;
  logic       err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  color_mux_seq uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .phase_i      (phase_i),
    .cfg_single_i (cfg_single_i),
    .cfg_reverse_i(cfg_reverse_i),
    .cfg_chan_i   (cfg_chan_i),
    .sel_o        (sel_o),
    .sample_o     (sample_o),
    .tag_o        (tag_o),
    .err_o        (err_o)
  );

  typedef struct packed {
    logic       ls;
    logic       ph;
    logic       sg;
    logic       rv;
    logic [1:0] ch;
    logic [2:0] esel;
    logic       esmp;
    logic [1:0] etag;
    logic       eerr;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,2'd0,3'b001,1'b0,2'd0,1'b0}, // 0  R4 line start fwd
    '{1'b0,1'b1,1'b0,1'b0,2'd0,3'b010,1'b1,2'd0,1'b0}, // 1  R2 R8
    '{1'b0,1'b1,1'b0,1'b0,2'd0,3'b100,1'b1,2'd1,1'b0}, // 2
    '{1'b0,1'b1,1'b0,1'b0,2'd0,3'b001,1'b1,2'd2,1'b0}, // 3  wrap
    '{1'b0,1'b0,1'b0,1'b0,2'd0,3'b001,1'b0,2'd2,1'b0}, // 4  tag holds
    '{1'b0,1'b1,1'b0,1'b1,2'd0,3'b010,1'b1,2'd0,1'b0}, // 5  R5 reverse not yet taken
    '{1'b1,1'b0,1'b0,1'b1,2'd0,3'b100,1'b0,2'd0,1'b0}, // 6  R3 R4 restart at blue
    '{1'b0,1'b1,1'b0,1'b1,2'd0,3'b010,1'b1,2'd2,1'b0}, // 7
    '{1'b0,1'b1,1'b0,1'b1,2'd0,3'b001,1'b1,2'd1,1'b0}, // 8
    '{1'b0,1'b1,1'b0,1'b1,2'd0,3'b100,1'b1,2'd0,1'b0}, // 9  wrap
    '{1'b0,1'b1,1'b1,1'b1,2'd1,3'b010,1'b1,2'd2,1'b0}, // 10 R5 single not yet taken
    '{1'b1,1'b1,1'b1,1'b1,2'd1,3'b010,1'b0,2'd2,1'b0}, // 11 R4 phase dropped, R6 green
    '{1'b0,1'b1,1'b1,1'b1,2'd1,3'b010,1'b1,2'd1,1'b0}, // 12 R6 hold
    '{1'b0,1'b1,1'b1,1'b1,2'd2,3'b010,1'b1,2'd1,1'b0}, // 13 R5 chan change ignored
    '{1'b1,1'b0,1'b1,1'b1,2'd2,3'b100,1'b0,2'd1,1'b0}, // 14 R6 blue
    '{1'b0,1'b1,1'b1,1'b1,2'd2,3'b100,1'b1,2'd2,1'b0}, // 15
    '{1'b1,1'b0,1'b0,1'b0,2'd2,3'b001,1'b0,2'd2,1'b0}, // 16 R6 field ignored in cycling
    '{1'b0,1'b1,1'b0,1'b0,2'd3,3'b010,1'b1,2'd0,1'b0}, // 17 R8
    '{1'b1,1'b0,1'b0,1'b0,2'd3,3'b001,1'b0,2'd0,1'b0}, // 18 R7 no err in cycling
    '{1'b1,1'b0,1'b1,1'b0,2'd3,3'b001,1'b0,2'd0,1'b1}, // 19 R7 reserved -> red, err
    '{1'b0,1'b1,1'b1,1'b0,2'd3,3'b001,1'b1,2'd0,1'b1}, // 20
    '{1'b1,1'b0,1'b1,1'b0,2'd0,3'b001,1'b0,2'd0,1'b1}, // 21 R7 sticky
    '{1'b1,1'b0,1'b0,1'b0,2'd0,3'b001,1'b0,2'd0,1'b1}  // 22 R7 sticky
  };

  function automatic string vec_req(int idx);
    if (idx == 0) return "R4";
    if (idx <= 4) return "R2_R8";
    if (idx == 5) return "R5";
    if (idx == 6) return "R3_R4";
    if (idx <= 9) return "R3_R8";
    if (idx == 10) return "R5";
    if (idx == 11) return "R4_R6";
    if (idx == 12) return "R6_R8";
    if (idx == 13) return "R5_R6";
    if (idx <= 16) return "R6";
    if (idx == 17) return "R8";
    return "R7";
  endfunction

  task automatic check(string req, string what, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic ls, logic ph, logic sg, logic rv, logic [1:0] ch);
    line_start_i  = ls;
    phase_i       = ph;
    cfg_single_i  = sg;
    cfg_reverse_i = rv;
    cfg_chan_i    = ch;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "sel in reset", sel_o, 3'b001);
    check("R1", "sample in reset", {2'b0, sample_o}, 3'b000);
    check("R1", "err in reset", {2'b0, err_o}, 3'b000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1", "tag after reset", {1'b0, tag_o}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].ls, VECS[i].ph, VECS[i].sg, VECS[i].rv, VECS[i].ch);
      @(posedge clk); #1;
      check({vec_req(i), "_R9"}, $sformatf("vec%0d sel", i), sel_o, VECS[i].esel);
      check(vec_req(i), $sformatf("vec%0d sample", i), {2'b0, sample_o}, {2'b0, VECS[i].esmp});
      check(vec_req(i), $sformatf("vec%0d tag", i), {1'b0, tag_o}, {1'b0, VECS[i].etag});
      check(vec_req(i), $sformatf("vec%0d err", i), {2'b0, err_o}, {2'b0, VECS[i].eerr});
    end

    // R1: asynchronous reset mid-run clears the sticky flag
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'd2);
    rst_ni = 1'b0;
    #1;
    check("R1", "err async clear", {2'b0, err_o}, 3'b000);
    check("R1", "sel async reset", sel_o, 3'b001);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: default config is cycling forward even with other inputs present
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd2);
    @(posedge clk); #1;
    check("R1", "first step green", sel_o, 3'b010);
    check("R1", "first tag red", {1'b0, tag_o}, 3'b000);
    @(posedge clk); #1;
    check("R1", "second step blue", sel_o, 3'b100);
    check("R1", "sample pulse", {2'b0, sample_o}, 3'b001);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    @(posedge clk); #1;
    check("R8", "sample single cycle", {2'b0, sample_o}, 3'b000);
    check("R8", "tag held", {1'b0, tag_o}, 3'b001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule